// File: doc/BRIEF.md
# Pin Interrupt Controller

This block turns eight external input lines into eight interrupt requests for a parent interrupt controller. Each channel can be in edge mode or in level mode. In edge mode, rising and falling transitions are enabled independently. A detected transition is latched in a sticky detect bit, and the request stays asserted until software acknowledges it. In level mode, the rising-enable bit gates the channel and the falling-enable bit picks the active polarity. The request then follows the synchronised input directly.

Software uses a small register window with byte-wide data. Bit n of every register belongs to channel n. Both enable vectors can be written directly, and each also has a set-strobe address and a clear-strobe address. At a strobe address, ones in the written value act and zeros have no effect. The inputs pass through a two-flop synchroniser before any detection. Channel n drives `irq_out[n]`, which the parent is expected to treat as an edge-type request on its line 32+n.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset every readable register reads 0, all channels are in edge mode with both enables clear, and `irq_out` is 0.
- R2: Writing to offset 0x08 sets the rising-enable bits (readable at 0x04) where the data has a one; writing to 0x14 does the same for the falling-enable bits (readable at 0x10). Zero data bits leave their bits unchanged.
- R3: Writing to offset 0x0C clears the rising-enable bits where the data has a one; writing to 0x18 does the same for the falling-enable bits. Zero data bits leave their bits unchanged.
- R4: Offsets 0x00 (mode, where 1 means level and 0 means edge), 0x04 and 0x10 are written directly and read back the value written. Strobe offsets read as 0.
- R5: In edge mode, a 0-to-1 input change on a channel whose rising enable is set sets its rising-detect bit (read at 0x1C) and raises `irq_out[n]` no later than the fourth clock edge after the change.
- R6: An input transition whose matching enable bit is clear sets no detect bit and raises no request.
- R7: In edge mode, a 1-to-0 input change on a channel whose falling enable is set sets its falling-detect bit (read at 0x20) and raises `irq_out[n]`.
- R8: Writing a one to bit n at offset 0x24 clears both detect bits of an edge-mode channel n and drops its request. Channels with a zero data bit keep their requests.
- R9: Writing ones to offset 0x1C or 0x20 clears only the matching rising-detect or falling-detect bits.
- R10: In level mode, `irq_out[n]` is 1 exactly when the rising enable is set and the synchronised input equals the falling-enable bit (1 = active high, 0 = active low).
- R11: In level mode, a write to offset 0x24 has no effect on the request.
- R12: Reading offset 0x24 returns the current `irq_out` vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 6 | Byte offset of the register |
| reg_wdata | input | 8 | Write data, one bit per channel |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| pin_in | input | 8 | Already-selected input lines, asynchronous |
| irq_out | output | 8 | Per-channel interrupt requests |

## Verification
The assertions assume that a write lasts a single cycle and lands on one offset. They also assume that the new value of a detect bit is judged against the enable and event values of the previous cycle. This holds because the bench drives `reg_wr` for exactly one clock and changes `pin_in` only at falling edges. The bench never changes a pin in the same cycle as a clear of the bit that pin would set. That cycle is the only case where the assertions' set-before-clear view could meet a race in the stimulus.

// File: rtl/pin_irq_pkg.sv
`timescale 1ns/1ps
package pin_irq_pkg;
  localparam int ADDR_W = 6;

  typedef enum logic [ADDR_W-1:0] {
    OFF_MODE = 6'h00,
    OFF_RENA = 6'h04,
    OFF_RSET = 6'h08,
    OFF_RCLR = 6'h0C,
    OFF_FENA = 6'h10,
    OFF_FSET = 6'h14,
    OFF_FCLR = 6'h18,
    OFF_RDET = 6'h1C,
    OFF_FDET = 6'h20,
    OFF_STAT = 6'h24
  } reg_off_e;

  // Level request: enabled and input matches the chosen polarity.
  function automatic logic level_req(logic en, logic pol_high, logic lvl);
    return en & (pol_high ? lvl : ~lvl);
  endfunction

  // Edge request: any latched transition.
  function automatic logic edge_req(logic rdet, logic fdet);
    return rdet | fdet;
  endfunction

  // Enable register update for direct write, set strobe, clear strobe.
  function automatic logic [7:0] ena_next(logic [7:0] cur, logic [7:0] wd,
                                          logic wr_dir, logic wr_set, logic wr_clr);
    if (wr_dir)      return wd;
    else if (wr_set) return cur | wd;
    else if (wr_clr) return cur & ~wd;
    else             return cur;
  endfunction
endpackage

// File: rtl/pin_irq_sync.sv
`timescale 1ns/1ps
module pin_irq_sync #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pin_in,
  output logic [NCH-1:0] sync_lvl,
  output logic [NCH-1:0] rise_ev,
  output logic [NCH-1:0] fall_ev
);
  logic [NCH-1:0] stage1_q, stage2_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
      prev_q   <= '0;
    end else begin
      stage1_q <= pin_in;
      stage2_q <= stage1_q;
      prev_q   <= stage2_q;
    end
  end

  assign sync_lvl = stage2_q;
  assign rise_ev  = stage2_q & ~prev_q;
  assign fall_ev  = ~stage2_q & prev_q;
endmodule

// File: rtl/pin_irq_chan.sv
`timescale 1ns/1ps
module pin_irq_chan
  import pin_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_mode,
  input  logic rena,
  input  logic fena,
  input  logic lvl,
  input  logic rise_ev,
  input  logic fall_ev,
  input  logic clr_rdet,
  input  logic clr_fdet,
  input  logic ack,
  output logic rdet,
  output logic fdet,
  output logic req
);
  logic ack_edge;
  assign ack_edge = ack & ~lvl_mode;

  // A new event wins over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdet <= 1'b0;
      fdet <= 1'b0;
    end else begin
      if (rise_ev && rena)            rdet <= 1'b1;
      else if (clr_rdet || ack_edge)  rdet <= 1'b0;
      if (fall_ev && fena)            fdet <= 1'b1;
      else if (clr_fdet || ack_edge)  fdet <= 1'b0;
    end
  end

  assign req = lvl_mode ? level_req(rena, fena, lvl) : edge_req(rdet, fdet);
endmodule

// File: rtl/pin_irq_ctrl.sv
`timescale 1ns/1ps
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NCH-1:0]    reg_wdata,
  output logic [NCH-1:0]    reg_rdata,
  input  logic [NCH-1:0]    pin_in,
  output logic [NCH-1:0]    irq_out
);
  logic [NCH-1:0] mode_q, rena_q, fena_q;
  logic [NCH-1:0] rdet_q, fdet_q;
  logic [NCH-1:0] sync_lvl, rise_ev, fall_ev;

  // Decoded write strobes, brought out for the checker.
  logic wr_mode, wr_rena, wr_rset, wr_rclr, wr_fena, wr_fset, wr_fclr;
  logic wr_rdet, wr_fdet, wr_stat;

  assign wr_mode = reg_wr && (reg_addr == OFF_MODE);
  assign wr_rena = reg_wr && (reg_addr == OFF_RENA);
  assign wr_rset = reg_wr && (reg_addr == OFF_RSET);
  assign wr_rclr = reg_wr && (reg_addr == OFF_RCLR);
  assign wr_fena = reg_wr && (reg_addr == OFF_FENA);
  assign wr_fset = reg_wr && (reg_addr == OFF_FSET);
  assign wr_fclr = reg_wr && (reg_addr == OFF_FCLR);
  assign wr_rdet = reg_wr && (reg_addr == OFF_RDET);
  assign wr_fdet = reg_wr && (reg_addr == OFF_FDET);
  assign wr_stat = reg_wr && (reg_addr == OFF_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      rena_q <= '0;
      fena_q <= '0;
    end else begin
      if (wr_mode) mode_q <= reg_wdata;
      rena_q <= ena_next(rena_q, reg_wdata, wr_rena, wr_rset, wr_rclr);
      fena_q <= ena_next(fena_q, reg_wdata, wr_fena, wr_fset, wr_fclr);
    end
  end

  pin_irq_sync #(.NCH(NCH)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (pin_in),
    .sync_lvl (sync_lvl),
    .rise_ev  (rise_ev),
    .fall_ev  (fall_ev)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    pin_irq_chan u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl_mode (mode_q[n]),
      .rena     (rena_q[n]),
      .fena     (fena_q[n]),
      .lvl      (sync_lvl[n]),
      .rise_ev  (rise_ev[n]),
      .fall_ev  (fall_ev[n]),
      .clr_rdet (wr_rdet && reg_wdata[n]),
      .clr_fdet (wr_fdet && reg_wdata[n]),
      .ack      (wr_stat && reg_wdata[n]),
      .rdet     (rdet_q[n]),
      .fdet     (fdet_q[n]),
      .req      (irq_out[n])
    );
  end

  always_comb begin
    case (reg_addr)
      OFF_MODE: reg_rdata = mode_q;
      OFF_RENA: reg_rdata = rena_q;
      OFF_FENA: reg_rdata = fena_q;
      OFF_RDET: reg_rdata = rdet_q;
      OFF_FDET: reg_rdata = fdet_q;
      OFF_STAT: reg_rdata = irq_out;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pin_irq_ctrl_chk.sv
`timescale 1ns/1ps
module pin_irq_ctrl_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] reg_wdata,
  input logic           wr_rset,
  input logic           wr_rclr,
  input logic           wr_stat,
  input logic [NCH-1:0] mode_q,
  input logic [NCH-1:0] rena_q,
  input logic [NCH-1:0] fena_q,
  input logic [NCH-1:0] rdet_q,
  input logic [NCH-1:0] fdet_q,
  input logic [NCH-1:0] sync_lvl,
  input logic [NCH-1:0] rise_ev,
  input logic [NCH-1:0] irq_out
);
  assert_set_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rset |=> ((rena_q & $past(reg_wdata)) == $past(reg_wdata)));

  assert_clr_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rclr |=> ((rena_q & $past(reg_wdata)) == '0));

  assert_edge_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_out & ~mode_q & ~(rdet_q | fdet_q)) == '0));

  assert_gated_detect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rdet_q & ~$past(rdet_q) & ~$past(rena_q & rise_ev)) == '0));

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> ((rdet_q & $past(reg_wdata & ~mode_q) & ~$past(rena_q & rise_ev)) == '0));

  assert_level_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_out & mode_q) == (mode_q & rena_q & ~(sync_lvl ^ fena_q))));
endmodule

bind pin_irq_ctrl pin_irq_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wdata (reg_wdata),
  .wr_rset   (wr_rset),
  .wr_rclr   (wr_rclr),
  .wr_stat   (wr_stat),
  .mode_q    (mode_q),
  .rena_q    (rena_q),
  .fena_q    (fena_q),
  .rdet_q    (rdet_q),
  .fdet_q    (fdet_q),
  .sync_lvl  (sync_lvl),
  .rise_ev   (rise_ev),
  .irq_out   (irq_out)
);

// File: tb/pin_irq_ctrl_test.sv
`timescale 1ns/1ps
module pin_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] pin_in = '0;
  logic [7:0] irq_out;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  pin_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in), .irq_out(irq_out)
  );

  // Row: [31] write, [29:24] offset, [23:16] data, [15:8] pins, [7:0] expected irq
  localparam logic [31:0] VEC [9] = '{
    32'h880F_0000,  // R2: set rising enables on ch0-3
    32'h0000_FF0F,  // R5/R6: rise on all, only ch0-3 enabled
    32'h94F0_FF0F,  // R2: set falling enables on ch4-7
    32'h0000_00FF,  // R7: fall on all, ch4-7 latch
    32'hA403_00FC,  // R8: ack ch0,1
    32'h9C0C_00F0,  // R9: clear rising detect ch2,3
    32'hA0F0_0000,  // R9: clear falling detect ch4-7
    32'h8C0F_0000,  // R3: clear rising enables
    32'h0000_FF00   // R6: rise with enables cleared
  };

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 irq", irq_out, 8'h00);
    foreach (VEC[i]) begin
      rd(6'(i * 4), d);
      check("R1 reg", d, 8'h00);
    end

    for (int i = 0; i < 9; i++) begin
      if (VEC[i][31]) wr(VEC[i][29:24], VEC[i][23:16]);
      @(negedge clk);
      pin_in = VEC[i][15:8];
      settle();
      check($sformatf("table row %0d", i), irq_out, VEC[i][7:0]);
    end

    // R4 direct writes and readback
    rd(6'h04, d); check("R3 rena cleared", d, 8'h00);
    rd(6'h10, d); check("R2 fena", d, 8'hF0);
    rd(6'h08, d); check("R4 strobe reads zero", d, 8'h00);
    wr(6'h00, 8'hFF);
    rd(6'h00, d); check("R4 mode", d, 8'hFF);
    wr(6'h10, 8'h01);
    rd(6'h10, d); check("R4 fena direct", d, 8'h01);
    wr(6'h18, 8'h01);
    rd(6'h10, d); check("R3 fclr", d, 8'h00);
    wr(6'h10, 8'h01);
    wr(6'h08, 8'h03);
    rd(6'h04, d); check("R2 rset keeps zeros", d, 8'h03);

    // R10 level mode: ch0 active high, ch1 active low; pins are all high
    settle();
    check("R10 level high", irq_out, 8'h01);
    @(negedge clk); pin_in = 8'h00;
    settle();
    check("R10 level low", irq_out, 8'h02);
    wr(6'h24, 8'h03);
    check("R11 ack ignored in level mode", irq_out, 8'h02);
    rd(6'h24, d); check("R12 status read", d, 8'h02);
    wr(6'h0C, 8'h02);
    check("R10 gated by rising enable", irq_out, 8'h00);

    // R5 latency: irq up by the fourth edge after a rise on an edge channel
    wr(6'h00, 8'h00);
    wr(6'h04, 8'h00);
    wr(6'h14, 8'h00);
    settle();
    wr(6'h1C, 8'hFF);
    wr(6'h20, 8'hFF);
    wr(6'h08, 8'h80);
    @(negedge clk); pin_in = 8'h80;
    repeat (2) @(negedge clk);
    check("R5 not yet", irq_out, 8'h00);
    repeat (2) @(negedge clk);
    check("R5 raised", irq_out, 8'h80);
    rd(6'h1C, d); check("R5 rising detect", d, 8'h80);
    rd(6'h24, d); check("R12 status edge", d, 8'h80);
    finish_run();
  end
endmodule